// File: doc/BRIEF.md
# Block Cipher Message Padder

This unit sits in front of a 128-bit block cipher. It takes a message as a stream of bytes and packs them into 16-byte blocks. At the end of the message it adds bit padding: a single 1 bit, written as the byte 0x80 because messages are whole bytes, and then zero bytes up to the block boundary. If the message already ends on a block boundary, the unit adds one more block. That block holds 0x80 followed by fifteen zero bytes.

The byte side has a valid/ready handshake with a last flag. It also has an empty qualifier, so a message can end on a beat that carries no byte. This is how a zero-length message is signalled. The block side has a valid/ready handshake and a last flag, which marks the block that holds the padding marker. While a finished block waits for the consumer, the byte side is stalled. It also stays stalled while the extra padding block is produced.

Top module: `msg_padder`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: Bytes are packed in arrival order with the first byte in out_data[127:120]. Byte k of a block sits at out_data[127-8k -: 8]. A block filled by 16 bytes with in_last low is emitted with out_last low.
- R3: When a message ends with a byte at block position p < 15, out_data holds that block's bytes, then 0x80 at position p+1, then zero bytes. out_last is high.
- R4: When the final byte fills position 15, the data block is emitted with out_last low. It is followed by a second block equal to 0x80 and fifteen zero bytes, with out_last high.
- R5: A beat with in_last and in_empty both high and no bytes collected produces one block of 0x80 and fifteen zero bytes, with out_last high.
- R6: A beat with in_last and in_empty both high after p collected bytes (0 < p < 16) ends the message with the marker at position p. The zero fill follows it.
- R7: A beat with in_empty high and in_last low contributes no byte and has no effect on the collected block.
- R8: in_ready is low while out_valid is high or the extra padding block is pending. out_data and out_last hold their values while out_valid is high and out_ready is low.
- R9: out_valid rises on the clock edge that accepts the beat completing a block. It falls on the edge of the handshake that takes the last block of the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Message byte |
| in_valid | input | 1 | Input beat valid |
| in_last | input | 1 | Beat ends the message |
| in_empty | input | 1 | Beat carries no byte |
| in_ready | output | 1 | Unit accepts an input beat |
| out_data | output | 128 | Output block, first byte in the top bits |
| out_valid | output | 1 | Output block valid |
| out_last | output | 1 | Block holds the padding marker |
| out_ready | input | 1 | Consumer takes the block |

## Verification
The assertions assume that in_valid and the beat fields are driven only with defined values. They assume nothing about how long out_ready stays low. The hold and padding properties also rely on out_ready being sampled only while out_valid is high. The bench drives every beat on the falling edge and holds it until the unit is ready. It raises out_ready for exactly one rising edge, and only after it has seen a valid block. As a result, every handshake falls inside these assumptions, and so do the stall windows that the hold property covers.

// File: rtl/msg_padder.sv
module msg_padder #(
  parameter int BYTES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         in_data,
  input  logic               in_valid,
  input  logic               in_last,
  input  logic               in_empty,
  output logic               in_ready,
  output logic [8*BYTES-1:0] out_data,
  output logic               out_valid,
  output logic               out_last,
  input  logic               out_ready
);
  localparam int W  = 8 * BYTES;
  localparam int CW = $clog2(BYTES) + 1;
  localparam logic [W-1:0] MARK = {8'h80, {(W-8){1'b0}}};

  logic [W-1:0]  acc, blk;
  logic [CW-1:0] cnt;
  logic          pend, ovalid, olast;

  wire           has_byte  = !in_empty;
  wire           accept    = in_valid && in_ready;
  wire           take_out  = ovalid && out_ready;
  wire [CW-1:0]  nxt       = cnt + CW'(has_byte);
  wire           full      = (nxt == CW'(BYTES));
  wire [W-1:0]   byte_at   = {in_data, {(W-8){1'b0}}} >> {cnt, 3'b000};
  wire [W-1:0]   mark_at   = MARK >> {nxt, 3'b000};
  wire [W-1:0]   with_byte = acc | (has_byte ? byte_at : '0);

  assign in_ready  = !ovalid && !pend;
  assign out_data  = blk;
  assign out_valid = ovalid;
  assign out_last  = olast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      blk    <= '0;
      cnt    <= '0;
      pend   <= 1'b0;
      ovalid <= 1'b0;
      olast  <= 1'b0;
    end else begin
      if (take_out) begin
        if (pend) begin
          blk   <= MARK;
          olast <= 1'b1;
          pend  <= 1'b0;
        end else begin
          ovalid <= 1'b0;
        end
      end
      if (accept && (has_byte || in_last)) begin
        if (in_last) begin
          ovalid <= 1'b1;
          acc    <= '0;
          cnt    <= '0;
          if (full) begin
            blk   <= with_byte;
            olast <= 1'b0;
            pend  <= 1'b1;
          end else begin
            blk   <= with_byte | mark_at;
            olast <= 1'b1;
          end
        end else if (full) begin
          blk    <= with_byte;
          olast  <= 1'b0;
          ovalid <= 1'b1;
          acc    <= '0;
          cnt    <= '0;
        end else begin
          acc <= with_byte;
          cnt <= nxt;
        end
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_pend_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> out_valid && !out_last);

  assert_pad_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_out && pend |=> out_valid && out_last && out_data == MARK);

  assert_tail_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> (out_data[7:0] == 8'h80 || out_data[7:0] == 8'h00));

  assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(BYTES));

  assert_emit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_last |=> out_valid);

endmodule

// File: tb/msg_padder_bench.sv
module msg_padder_bench;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [7:0]   in_data = 0;
  logic         in_valid = 0, in_last = 0, in_empty = 0, out_ready = 0;
  logic         in_ready, out_valid, out_last;
  logic [127:0] out_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  msg_padder u_msg_padder (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_empty(in_empty), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .out_ready(out_ready));

  function automatic logic [127:0] expect_blk(int start, int n, bit mark);
    logic [127:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      if (i < n) r[127-8*i -: 8] = 8'((start + i) & 8'hFF);
      else if (i == n && mark) r[127-8*i -: 8] = 8'h80;
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(logic [7:0] d, bit last, bit empty);
    @(negedge clk);
    in_data = d; in_last = last; in_empty = empty; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0; in_last = 0; in_empty = 0;
  endtask

  task automatic take(logic [127:0] exp, bit exp_last, string req);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    check(out_data == exp, req, "data", out_data, exp);
    check(out_last == exp_last, req, "last", 128'(out_last), 128'(exp_last));
    out_ready = 1;
    @(posedge clk); #1;
    out_ready = 0;
  endtask

  task automatic put_run(int start, int n, bit last_on_final);
    for (int i = 0; i < n; i++)
      put(8'((start + i) & 8'hFF), last_on_final && (i == n - 1), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(out_valid == 0, "R1", "out_valid", 128'(out_valid), 0);
    check(in_ready == 1, "R1", "in_ready", 128'(in_ready), 1);
  endtask

  task automatic t_full_then_short;
    put_run(8'h10, 15, 0);
    check(out_valid == 0, "R9", "no block before 16th byte", 128'(out_valid), 0);
    put(8'h1F, 0, 0);
    check(out_valid == 1, "R9", "valid on completing edge", 128'(out_valid), 1);
    check(in_ready == 0, "R8", "stall while block waits", 128'(in_ready), 0);
    repeat (3) @(negedge clk);
    check(out_data == expect_blk(8'h10, 16, 0), "R8", "held data", out_data, expect_blk(8'h10, 16, 0));
    take(expect_blk(8'h10, 16, 0), 0, "R2");
    @(negedge clk);
    check(out_valid == 0, "R9", "valid falls after take", 128'(out_valid), 0);
    put_run(8'h40, 5, 1);
    take(expect_blk(8'h40, 5, 1), 1, "R3");
  endtask

  task automatic t_one_byte;
    put(8'hAB, 1, 0);
    take({8'hAB, 8'h80, 112'b0}, 1, "R3");
  endtask

  task automatic t_fifteen;
    put_run(8'hE0, 15, 1);
    take(expect_blk(8'hE0, 15, 1), 1, "R3");
  endtask

  task automatic t_aligned;
    put_run(8'h70, 16, 1);
    @(negedge clk);
    check(in_ready == 0, "R8", "stall with pad pending", 128'(in_ready), 0);
    take(expect_blk(8'h70, 16, 0), 0, "R4");
    @(negedge clk);
    check(in_ready == 0, "R8", "stall during pad block", 128'(in_ready), 0);
    take({8'h80, 120'b0}, 1, "R4");
    @(negedge clk);
    check(out_valid == 0 && in_ready == 1, "R9", "idle after pad", 128'({out_valid, in_ready}), 128'b01);
  endtask

  task automatic t_zero_len;
    put(8'h55, 1, 1);
    take({8'h80, 120'b0}, 1, "R5");
  endtask

  task automatic t_empty_last;
    put_run(8'h20, 6, 0);
    put(8'hFF, 1, 1);
    take(expect_blk(8'h20, 6, 1), 1, "R6");
  endtask

  task automatic t_ignored;
    put_run(8'h30, 3, 0);
    put(8'hEE, 0, 1);
    @(negedge clk);
    check(out_valid == 0, "R7", "no output from empty beat", 128'(out_valid), 0);
    put(8'h33, 1, 0);
    take(expect_blk(8'h30, 4, 1), 1, "R7");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_full_then_short();
    t_one_byte();
    t_fifteen();
    t_aligned();
    t_zero_len();
    t_empty_last();
    t_ignored();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule